// File: doc/BRIEF.md
# Time-Shared Second-Order Recurrence Engine

This block evaluates a second-order linear recurrence with one shared multiplier and one shared adder. Three coefficient inputs A, B and C stay constant for the whole run. Each iteration produces one result, Z = A·Y2 + B·Y1 + C, where Y1 is the previous result and Y2 the one before it. The block keeps both history values internally, and after a reset both are zero.

A small sequencer steps through eight register-transfer steps, one clock cycle per step. These steps load two operand registers, route them through the multiplier or the adder into an accumulator, and park one partial product in a temporary register. The last step shifts the history, publishes the new result on `z` and raises `z_valid` for one cycle.

The result leaves the block as a valid-only stream with no ready input. A consumer that cannot take the next result must lower `en` before that result is due. While `en` is low, every register and the step position are frozen, so nothing is lost. The coefficients must not change while a run is in progress.

Top module: `rsq_recurrence_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `z` to 0 and `z_valid` to 0, clears both history values and the working registers, and returns the sequencer to its first step.
- R2: The first result after reset equals C, because both history values start at zero.
- R3: Every result equals A·Y2 + B·Y1 + C. Here Y1 is the result published just before it and Y2 the one before that, with zero used for any history not yet produced.
- R4: With `en` held high from the release of reset, `z_valid` is high after the 8th rising edge and then after every further 8th rising edge. It is never high at any other time.
- R5: `z_valid` is high for exactly one cycle per result. `z` changes only in a cycle in which `z_valid` is high, and otherwise holds its last value.
- R6: While `en` is low, the sequencer and all internal registers keep their values, `z` does not change and `z_valid` stays low. When `en` returns high, the iteration resumes at the step where it stopped. A result is therefore due after 8 enabled edges in total.
- R7: All products and sums are unsigned and truncated to the low N bits (N = 16 by default). The wrap-around result modulo 2^N feeds the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Step enable; low freezes the block |
| coef_a | input | N | Coefficient applied to the older history value |
| coef_b | input | N | Coefficient applied to the newer history value |
| coef_c | input | N | Constant term |
| z | output | N | Latest result |
| z_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench goes after the first result after reset. A design that failed to clear the history would report a value other than C there. It checks that the two history values are not swapped, since swapped values give B·Y2 + A·Y1 + C and asymmetric coefficients expose that within two iterations. All-ones coefficients and large values exercise truncation, where a design that widened or saturated would drift from the modulo-2^16 reference. A stall in the middle of an iteration and a reset in the middle of a run catch a sequencer that keeps counting while disabled, restarts the iteration on resume, or keeps stale history across a reset.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int unsigned STEP_COUNT = 8;

  // Step order is behaviour: each step consumes what the previous one loaded.
  typedef enum logic [2:0] {
    ST_LOAD_A = 3'd0,   // operands <- A, older history
    ST_MUL_A  = 3'd1,   // acc <- product; operands <- B, newer history
    ST_MUL_B  = 3'd2,   // tmp <- acc; acc <- product
    ST_LOAD_C = 3'd3,   // operands <- C, acc
    ST_ADD_C  = 3'd4,   // acc <- sum
    ST_LOAD_T = 3'd5,   // operands <- tmp, acc
    ST_ADD_T  = 3'd6,   // acc <- sum
    ST_COMMIT = 3'd7    // history shift, publish result
  } step_e;

  typedef enum logic [1:0] {
    OPL_COEF_A = 2'd0,
    OPL_COEF_B = 2'd1,
    OPL_COEF_C = 2'd2,
    OPL_TMP    = 2'd3
  } opl_sel_e;

  typedef enum logic [1:0] {
    OPR_HIST_OLD = 2'd0,
    OPR_HIST_NEW = 2'd1,
    OPR_ACC      = 2'd2
  } opr_sel_e;

  typedef enum logic {
    FU_MUL = 1'b0,
    FU_ADD = 1'b1
  } fu_sel_e;

  typedef struct packed {
    logic     opnd_ld;
    opl_sel_e opl_sel;
    opr_sel_e opr_sel;
    logic     acc_ld;
    fu_sel_e  fu_sel;
    logic     tmp_ld;
    logic     commit;
  } ctl_t;

endpackage

// File: rtl/rsq_sequencer.sv
module rsq_sequencer
  import rsq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  output step_e step_o,
  output ctl_t  ctl_o
);

  step_e step_q;
  step_e step_nxt;
  ctl_t  ctl_raw;

  always_comb begin
    if (step_q == ST_COMMIT) step_nxt = ST_LOAD_A;
    else                     step_nxt = step_e'(step_q + 3'd1);
  end

  always_ff @(posedge clk) begin
    if (rst)     step_q <= ST_LOAD_A;
    else if (en) step_q <= step_nxt;
  end

  // Per-step control decode.
  always_comb begin
    ctl_raw = '0;
    unique case (step_q)
      ST_LOAD_A: begin
        ctl_raw.opnd_ld = 1'b1;
        ctl_raw.opl_sel = OPL_COEF_A;
        ctl_raw.opr_sel = OPR_HIST_OLD;
      end
      ST_MUL_A: begin
        ctl_raw.acc_ld  = 1'b1;
        ctl_raw.fu_sel  = FU_MUL;
        ctl_raw.opnd_ld = 1'b1;
        ctl_raw.opl_sel = OPL_COEF_B;
        ctl_raw.opr_sel = OPR_HIST_NEW;
      end
      ST_MUL_B: begin
        ctl_raw.tmp_ld  = 1'b1;
        ctl_raw.acc_ld  = 1'b1;
        ctl_raw.fu_sel  = FU_MUL;
      end
      ST_LOAD_C: begin
        ctl_raw.opnd_ld = 1'b1;
        ctl_raw.opl_sel = OPL_COEF_C;
        ctl_raw.opr_sel = OPR_ACC;
      end
      ST_ADD_C: begin
        ctl_raw.acc_ld  = 1'b1;
        ctl_raw.fu_sel  = FU_ADD;
      end
      ST_LOAD_T: begin
        ctl_raw.opnd_ld = 1'b1;
        ctl_raw.opl_sel = OPL_TMP;
        ctl_raw.opr_sel = OPR_ACC;
      end
      ST_ADD_T: begin
        ctl_raw.acc_ld  = 1'b1;
        ctl_raw.fu_sel  = FU_ADD;
      end
      ST_COMMIT: begin
        ctl_raw.commit  = 1'b1;
      end
      default: ctl_raw = '0;
    endcase
  end

  // A disabled cycle issues no transfers at all.
  always_comb begin
    if (en) ctl_o = ctl_raw;
    else    ctl_o = '0;
  end

  assign step_o = step_q;

  AST_HOLD_STEP: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(step_q)); // R6

  AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (en && step_q == ST_COMMIT) |=> (step_q == ST_LOAD_A)); // R4

endmodule

// File: rtl/rsq_arith.sv
module rsq_arith
  import rsq_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] op_l,
  input  logic [N-1:0] op_r,
  input  fu_sel_e      fu_sel,
  output logic [N-1:0] result
);

  localparam int unsigned PW = 2 * N;

  logic [PW-1:0] prod_full;
  logic [N-1:0]  sum_low;

  // The full product is formed and then the low half is kept (modulo 2^N).
  assign prod_full = PW'(op_l) * PW'(op_r);
  assign sum_low   = op_l + op_r;

  always_comb begin
    unique case (fu_sel)
      FU_MUL:  result = prod_full[N-1:0];
      FU_ADD:  result = sum_low;
      default: result = sum_low;
    endcase
  end

endmodule

// File: rtl/rsq_datapath.sv
module rsq_datapath
  import rsq_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  ctl_t         ctl_i,
  input  logic [N-1:0] coef_a,
  input  logic [N-1:0] coef_b,
  input  logic [N-1:0] coef_c,
  output logic [N-1:0] z_o,
  output logic         z_valid_o
);

  logic [N-1:0] opl_q, opr_q;
  logic [N-1:0] acc_q, tmp_q;
  logic [N-1:0] hist_new_q, hist_old_q;
  logic [N-1:0] z_q;
  logic         zv_q;
  logic [N-1:0] opl_d, opr_d;
  logic [N-1:0] fu_res;

  always_comb begin
    unique case (ctl_i.opl_sel)
      OPL_COEF_A: opl_d = coef_a;
      OPL_COEF_B: opl_d = coef_b;
      OPL_COEF_C: opl_d = coef_c;
      OPL_TMP:    opl_d = tmp_q;
      default:    opl_d = tmp_q;
    endcase
  end

  always_comb begin
    unique case (ctl_i.opr_sel)
      OPR_HIST_OLD: opr_d = hist_old_q;
      OPR_HIST_NEW: opr_d = hist_new_q;
      OPR_ACC:      opr_d = acc_q;
      default:      opr_d = acc_q;
    endcase
  end

  rsq_arith #(.N(N)) i_arith (
    .op_l   (opl_q),
    .op_r   (opr_q),
    .fu_sel (ctl_i.fu_sel),
    .result (fu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opl_q <= '0;
      opr_q <= '0;
    end else if (ctl_i.opnd_ld) begin
      opl_q <= opl_d;
      opr_q <= opr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               acc_q <= '0;
    else if (ctl_i.acc_ld) acc_q <= fu_res;
  end

  // The temporary captures the accumulator before it is overwritten in the same step.
  always_ff @(posedge clk) begin
    if (rst)               tmp_q <= '0;
    else if (ctl_i.tmp_ld) tmp_q <= acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_new_q <= '0;
      hist_old_q <= '0;
      z_q        <= '0;
    end else if (ctl_i.commit) begin
      hist_old_q <= hist_new_q;
      hist_new_q <= acc_q;
      z_q        <= acc_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) zv_q <= 1'b0;
    else     zv_q <= ctl_i.commit;
  end

  assign z_o       = z_q;
  assign z_valid_o = zv_q;

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == '0) |=> ($stable(opl_q) && $stable(opr_q) && $stable(acc_q)
                       && $stable(tmp_q) && $stable(hist_new_q)
                       && $stable(hist_old_q))); // R6

  AST_HISTORY_ORDER: assert property (@(posedge clk) disable iff (rst)
    zv_q |-> (hist_new_q == z_q)); // R3

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
    $countones({ctl_i.commit, ctl_i.acc_ld}) <= 1); // R5

endmodule

// File: rtl/rsq_recurrence_unit.sv
module rsq_recurrence_unit
  import rsq_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [N-1:0] coef_a,
  input  logic [N-1:0] coef_b,
  input  logic [N-1:0] coef_c,
  output logic [N-1:0] z,
  output logic         z_valid
);

  step_e step;
  ctl_t  ctl;

  rsq_sequencer i_seq (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .step_o (step),
    .ctl_o  (ctl)
  );

  rsq_datapath #(.N(N)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl_i     (ctl),
    .coef_a    (coef_a),
    .coef_b    (coef_b),
    .coef_c    (coef_c),
    .z_o       (z),
    .z_valid_o (z_valid)
  );

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    z_valid |=> !z_valid); // R5

  AST_Z_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (rst)
    !z_valid |-> $stable(z)); // R5

  AST_VALID_AFTER_LAST_STEP: assert property (@(posedge clk) disable iff (rst)
    z_valid |-> (step == ST_LOAD_A)); // R4

  AST_NO_VALID_WHEN_HELD: assert property (@(posedge clk) disable iff (rst)
    !en |=> !z_valid); // R6

endmodule

// File: tb/test_rsq_recurrence_unit.sv
module test_rsq_recurrence_unit;

  localparam int unsigned N = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 6;

  localparam logic [N-1:0] VEC_A [NVEC] = '{16'd3, 16'd0, 16'd1, 16'd1, 16'hFFFF, 16'd100};
  localparam logic [N-1:0] VEC_B [NVEC] = '{16'd2, 16'd0, 16'd1, 16'd1, 16'hFFFF, 16'd200};
  localparam logic [N-1:0] VEC_C [NVEC] = '{16'd1, 16'd5, 16'd0, 16'd1, 16'hFFFF, 16'd300};
  localparam int           VEC_K [NVEC] = '{6, 4, 5, 12, 6, 8};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [N-1:0] coef_a = '0, coef_b = '0, coef_c = '0;
  logic [N-1:0] z;
  logic         z_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsq_recurrence_unit #(.N(N)) i_rsq_recurrence_unit (
    .clk(clk), .rst(rst), .en(en),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .z(z), .z_valid(z_valid)
  );

  function automatic logic [N-1:0] model(input logic [N-1:0] a, b, c, y1, y2);
    logic [N-1:0] r;
    r = a * y2 + b * y1 + c;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Counts rising edges until z_valid is seen at a falling edge.
  task automatic wait_valid(input int start, output int cyc);
    cyc = start;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end while (!z_valid && cyc < 100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [N-1:0] y1, y2, expv, held;

    // R1: state under reset
    do_reset();
    check(z == '0, "R1 z after reset", z, 0);
    check(z_valid == 1'b0, "R1 z_valid after reset", z_valid, 0);

    // Table walk: R2, R3, R4, R5, R7
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      coef_a = VEC_A[v]; coef_b = VEC_B[v]; coef_c = VEC_C[v];
      en = 1'b1;
      y1 = '0; y2 = '0;
      cyc = 0;
      for (int k = 0; k < VEC_K[v]; k++) begin
        wait_valid(cyc, cyc);
        check(cyc == 8, "R4 cycles per result", cyc, 8);
        expv = model(coef_a, coef_b, coef_c, y1, y2);
        if (k == 0) check(z == coef_c, "R2 first result", z, coef_c);
        if (v >= 4) check(z == expv, "R7 wrapped result", z, expv);
        else        check(z == expv, "R3 recurrence result", z, expv);
        y2 = y1; y1 = expv;
        held = z;
        @(posedge clk); @(negedge clk);
        check(!z_valid, "R5 strobe one cycle", z_valid, 0);
        check(z == held, "R5 z held after strobe", z, held);
        cyc = 1;
      end
    end

    // R6: stall in the middle of an iteration
    do_reset();
    coef_a = 16'd7; coef_b = 16'd5; coef_c = 16'd3;
    en = 1'b1;
    y1 = '0; y2 = '0;
    wait_valid(0, cyc);
    expv = model(coef_a, coef_b, coef_c, y1, y2);
    check(z == expv, "R6 pre-stall result", z, expv);
    y2 = y1; y1 = expv; held = z;
    repeat (3) @(negedge clk);              // 3 enabled edges done
    en = 1'b0;
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      check(!z_valid, "R6 no strobe while held", z_valid, 0);
      check(z == held, "R6 z frozen while held", z, held);
    end
    en = 1'b1;
    wait_valid(3, cyc);
    check(cyc == 8, "R6 enabled edges to resume result", cyc, 8);
    expv = model(coef_a, coef_b, coef_c, y1, y2);
    check(z == expv, "R6 result after stall", z, expv);

    // R1/R2: reset in the middle of a run clears history
    repeat (4) @(negedge clk);
    do_reset();
    check(z == '0, "R1 z after mid-run reset", z, 0);
    en = 1'b1;
    wait_valid(0, cyc);
    check(cyc == 8, "R1 restart at first step", cyc, 8);
    check(z == coef_c, "R2 first result after mid-run reset", z, coef_c);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule